// File: doc/BRIEF.md
# ADC Power-Up Offset Calibration Sequencer

This block is the control layer between a two-channel sigma-delta converter's decimated sample stream and the rest of the audio path. It watches an active-low power-down pin. While the pin is low, it holds the control registers at their defaults, refuses software writes and drives zero samples. When the pin is released, it runs a fixed-length offset calibration. The interval is counted in sample-strobe pulses, and the block estimates each channel's DC offset digitally from the samples that arrive during that interval. After calibration it hands each channel on as the raw input minus the stored offset, saturated to 20 bits.

During calibration both outputs read zero and the PGA mute flag is forced high. Software can still write every register except the mute register at address 0x01. The mute register resets to "muted", so the path stays silent after calibration until software clears it. Two per-channel power-management inputs silence a channel without losing the stored offset, and re-enabling a channel does not start a new calibration. Pulling the pin low during calibration aborts it. The next release starts the count again from zero.

Top module: `adc_cal_seq`

## Requirements
- R1: While the synchronized power-down pin is low, the mute register (address 0x01, bit 0) is held at 1 and the gain register (address 0x02, eight bits) is held at its reset value 0x0C. Every register write in that phase is ignored.
- R2: Calibration starts when the synchronized pin goes from low to high. `cal_busy` rises on the third rising clock edge after `pdn_n` goes high: two synchronizer flops, then the state register.
- R3: Calibration lasts exactly CAL_LEN sample strobes, where CAL_LEN = SETTLE + 2^AVG_LOG2 (4128 by default). `cal_busy` is still high after strobe CAL_LEN-1 and is low after strobe CAL_LEN.
- R4: Both channel outputs are two's-complement zero during calibration and while the synchronized pin is low.
- R5: `pga_mute` is high throughout calibration. Outside calibration it follows mute register bit 0, which resets to 1, so the path stays muted after calibration until a write of 0 to address 0x01.
- R6: During calibration, writes to address 0x01 are ignored, while writes to other addresses (for example the gain register at 0x02) take effect on the next clock.
- R7: For each channel, the stored offset is the sum of the calibration samples with index SETTLE through CAL_LEN-1, floor-divided by 2^AVG_LOG2. The first SETTLE samples have no effect. The offset changes only on the clock where calibration completes.
- R8: In normal operation, with the channel enabled, each output equals the input minus that channel's stored offset, clamped to the range -524288 to 524287.
- R9: Clearing `pm_en[i]` forces channel i's output to zero. Setting it again neither reruns calibration nor changes the stored offset.
- R10: A low synchronized pin during calibration aborts it. After the next release, a full CAL_LEN strobes are again needed to complete it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pdn_n | input | 1 | Asynchronous active-low power-down pin |
| smp_stb | input | 1 | One-cycle pulse per sample period |
| pm_en | input | 2 | Per-channel power-management enable (1 = powered) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| raw_smp | input | 2x20 | Raw two's-complement samples, channel 1 in the upper half |
| out_smp | output | 2x20 | Gated, offset-corrected samples |
| pga_mute | output | 1 | PGA mute request |
| cal_busy | output | 1 | High during offset calibration |
| offset_val | output | 2x20 | Stored per-channel offset estimate |
| pga_gain | output | 8 | Gain register contents |

## Verification
Two situations are hard to reach from the ports. The first is an abort partway through calibration followed by a complete rerun. The second is proving that a mute write issued during calibration really was dropped. `pga_mute` is forced high during calibration anyway, so that write can only be judged after calibration ends. The bench uses a small configuration (four settling samples, eight averaged) to walk complete calibrations strobe by strobe. It issues the blocked write and an accepted gain write in the middle of a run, then reads the mute flag once the run ends. It also cuts a run short and repeats it with offsets chosen to drive the subtractor into both saturation limits. A stepped sweep across the whole input range then compares every output with an arithmetically computed clamp.

// File: rtl/adc_cal_pkg.sv
// Shared types and register addresses for the calibration sequencer.
// Assumes a 4-bit register address space; only addresses 0x01 and 0x02 exist.
package adc_cal_pkg;

    typedef enum logic [1:0] {
        ST_DOWN = 2'd0,
        ST_CAL  = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_t;

    localparam logic [3:0] MUTE_ADDR = 4'h1;
    localparam logic [3:0] GAIN_ADDR = 4'h2;

endpackage

// File: rtl/adc_cal_sync.sv
// Multi-flop synchronizer for the asynchronous power-down pin.
// Assumes the pin is quasi-static relative to clk; the output resets low.
module adc_cal_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/adc_cal_ctrl.sv
// Sequencer state and sample counter. Leaves DOWN on the rising edge of the
// synchronized pin, counts CAL_LEN strobes in CAL, then stays in RUN.
// A low pin at any time returns to DOWN and clears the count.
// Assumes SETTLE >= 1 and CAL_LEN >= 2.
module adc_cal_ctrl
    import adc_cal_pkg::*;
#(
    parameter int CAL_LEN = 4128,
    parameter int SETTLE  = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pdn_s,
    input  logic       smp_stb,
    output seq_state_t state,
    output logic       acc_en,
    output logic       cal_last
);

    localparam int CNT_W = $clog2(CAL_LEN);
    localparam logic [CNT_W-1:0] LAST_IDX   = CNT_W'(CAL_LEN - 1);
    localparam logic [CNT_W-1:0] SETTLE_IDX = CNT_W'(SETTLE);

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             in_cal;

    assign in_cal   = (state_q == ST_CAL);
    assign acc_en   = in_cal && smp_stb && (cnt_q >= SETTLE_IDX);
    assign cal_last = in_cal && smp_stb && (cnt_q == LAST_IDX);
    assign state    = state_q;

    // Advance the sequencer and count calibration strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || !pdn_s) begin
            state_q <= ST_DOWN;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_DOWN: begin
                    state_q <= ST_CAL;
                    cnt_q   <= '0;
                end
                ST_CAL: begin
                    if (smp_stb) begin
                        if (cnt_q == LAST_IDX) begin
                            state_q <= ST_RUN;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

endmodule

// File: rtl/adc_cal_regs.sv
// Control registers: mute (0x01 bit 0, resets to 1) and gain (0x02).
// Held at reset values while the synchronized pin is low; writes to the mute
// address are dropped while calibration runs.
module adc_cal_regs
    import adc_cal_pkg::*;
#(
    parameter int              DATA_W   = 8,
    parameter logic [DATA_W-1:0] GAIN_RST = 8'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pdn_s,
    input  logic              cal_busy,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              mute_cfg,
    output logic [DATA_W-1:0] gain_cfg
);

    logic wr_ok;

    assign wr_ok = wr_en && !(cal_busy && (wr_addr == MUTE_ADDR));

    // Hold defaults in power-down, otherwise accept permitted writes.
    always_ff @(posedge clk) begin
        if (!rst_n || !pdn_s) begin
            mute_cfg <= 1'b1;
            gain_cfg <= GAIN_RST;
        end else if (wr_ok) begin
            if (wr_addr == MUTE_ADDR) mute_cfg <= wr_data[0];
            if (wr_addr == GAIN_ADDR) gain_cfg <= wr_data;
        end
    end

endmodule

// File: rtl/adc_cal_offset.sv
// Per-channel offset estimator: accumulates 2^AVG_LOG2 samples and stores
// the floor average when the last calibration strobe arrives.
// Assumes cal_last coincides with acc_en. Only rst_n clears the stored value.
module adc_cal_offset #(
    parameter int SAMPLE_W = 20,
    parameter int AVG_LOG2 = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                acc_en,
    input  logic                cal_last,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [SAMPLE_W-1:0] offset
);

    localparam int ACC_W = SAMPLE_W + AVG_LOG2;

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] sum;
    logic signed [ACC_W-1:0] avg;

    assign sum = acc_q + ACC_W'($signed(sample));
    assign avg = sum >>> AVG_LOG2;

    // Accumulate calibration samples and latch the average at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            offset <= '0;
        end else begin
            if (clr)         acc_q <= '0;
            else if (acc_en) acc_q <= sum;
            if (cal_last)    offset <= avg[SAMPLE_W-1:0];
        end
    end

endmodule

// File: rtl/adc_cal_gate.sv
// Output path for one channel: subtract the offset, saturate to SAMPLE_W
// bits, and force zero unless enabled. Purely combinational.
module adc_cal_gate #(
    parameter int SAMPLE_W = 20
) (
    input  logic                en,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [SAMPLE_W-1:0] offset,
    output logic [SAMPLE_W-1:0] result
);

    localparam logic signed [SAMPLE_W:0] HI = {2'b00, {(SAMPLE_W-1){1'b1}}};
    localparam logic signed [SAMPLE_W:0] LO = {2'b11, {(SAMPLE_W-1){1'b0}}};

    logic signed [SAMPLE_W:0] diff;

    assign diff = $signed({sample[SAMPLE_W-1], sample}) - $signed({offset[SAMPLE_W-1], offset});

    // Clamp the difference and apply the enable.
    always_comb begin
        if (!en)            result = '0;
        else if (diff > HI) result = HI[SAMPLE_W-1:0];
        else if (diff < LO) result = LO[SAMPLE_W-1:0];
        else                result = diff[SAMPLE_W-1:0];
    end

endmodule

// File: rtl/adc_cal_seq.sv
// Top level of the power-up calibration sequencer. Synchronizes the
// power-down pin, runs the calibration interval, keeps the control registers
// and gates each channel's corrected sample stream.
// Assumes smp_stb is a single-cycle pulse and raw_smp is valid while it is high.
module adc_cal_seq
    import adc_cal_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int SAMPLE_W = 20,
    parameter int SETTLE   = 32,
    parameter int AVG_LOG2 = 12,
    parameter int DATA_W   = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             pdn_n,
    input  logic                             smp_stb,
    input  logic [NUM_CH-1:0]                pm_en,
    input  logic                             wr_en,
    input  logic [3:0]                       wr_addr,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic [NUM_CH-1:0][SAMPLE_W-1:0]  raw_smp,
    output logic [NUM_CH-1:0][SAMPLE_W-1:0]  out_smp,
    output logic                             pga_mute,
    output logic                             cal_busy,
    output logic [NUM_CH-1:0][SAMPLE_W-1:0]  offset_val,
    output logic [DATA_W-1:0]                pga_gain
);

    localparam int CAL_LEN = SETTLE + (1 << AVG_LOG2);

    logic       pdn_s;
    seq_state_t state;
    logic       acc_en;
    logic       cal_last;
    logic       mute_cfg;
    logic       run_on;

    adc_cal_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pdn_n),
        .sync_out (pdn_s)
    );

    adc_cal_ctrl #(.CAL_LEN(CAL_LEN), .SETTLE(SETTLE)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pdn_s    (pdn_s),
        .smp_stb  (smp_stb),
        .state    (state),
        .acc_en   (acc_en),
        .cal_last (cal_last)
    );

    assign cal_busy = (state == ST_CAL);
    assign run_on   = (state == ST_RUN);

    adc_cal_regs #(.DATA_W(DATA_W), .GAIN_RST(DATA_W'(8'h0C))) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .pdn_s    (pdn_s),
        .cal_busy (cal_busy),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .mute_cfg (mute_cfg),
        .gain_cfg (pga_gain)
    );

    assign pga_mute = mute_cfg | cal_busy;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        adc_cal_offset #(.SAMPLE_W(SAMPLE_W), .AVG_LOG2(AVG_LOG2)) u_off (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (!cal_busy),
            .acc_en   (acc_en),
            .cal_last (cal_last),
            .sample   (raw_smp[ch]),
            .offset   (offset_val[ch])
        );

        adc_cal_gate #(.SAMPLE_W(SAMPLE_W)) u_gate (
            .en     (run_on && pm_en[ch]),
            .sample (raw_smp[ch]),
            .offset (offset_val[ch]),
            .result (out_smp[ch])
        );
    end

endmodule

// File: rtl/adc_cal_seq_chk.sv
// Temporal checks for adc_cal_seq, attached with bind. Observes ports plus
// the synchronized pin and the mute register bit.
module adc_cal_seq_chk #(
    parameter int NUM_CH   = 2,
    parameter int SAMPLE_W = 20,
    parameter int DATA_W   = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            pdn_n,
    input logic                            pdn_s,
    input logic                            cal_busy,
    input logic                            pga_mute,
    input logic                            mute_cfg,
    input logic [DATA_W-1:0]               pga_gain,
    input logic                            wr_en,
    input logic [3:0]                      wr_addr,
    input logic [NUM_CH-1:0]               pm_en,
    input logic [NUM_CH-1:0][SAMPLE_W-1:0] out_smp,
    input logic [NUM_CH-1:0][SAMPLE_W-1:0] offset_val
);

    // R1
    pdn_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_s |=> (mute_cfg && pga_gain == DATA_W'(8'h0C)));

    // R2
    cal_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_busy) |-> $past(pdn_n, 2));

    // R4
    cal_zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |-> (out_smp == '0));

    // R5
    cal_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |-> pga_mute);

    // R6
    mute_wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy && wr_en && wr_addr == 4'h1) |=> $stable(mute_cfg));

    // R7
    offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(offset_val) |-> $fell(cal_busy));

    // R10
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_s |=> !cal_busy);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_pm
        // R9
        pm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pm_en[ch] |-> (out_smp[ch] == '0));
    end

endmodule

bind adc_cal_seq adc_cal_seq_chk #(
    .NUM_CH   (NUM_CH),
    .SAMPLE_W (SAMPLE_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pdn_n      (pdn_n),
    .pdn_s      (pdn_s),
    .cal_busy   (cal_busy),
    .pga_mute   (pga_mute),
    .mute_cfg   (mute_cfg),
    .pga_gain   (pga_gain),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .pm_en      (pm_en),
    .out_smp    (out_smp),
    .offset_val (offset_val)
);

// File: tb/adc_cal_seq_test.sv
// Bench for adc_cal_seq in a small configuration (SETTLE=4, 8 averaged).
module adc_cal_seq_test;

    localparam int SETTLE  = 4;
    localparam int AVG_L   = 3;
    localparam int NAVG    = 1 << AVG_L;
    localparam int CAL_LEN = SETTLE + NAVG;
    localparam longint SMAX = 524287;
    localparam longint SMIN = -524288;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pdn_n = 1'b0;
    logic             smp_stb = 1'b0;
    logic [1:0]       pm_en = 2'b11;
    logic             wr_en = 1'b0;
    logic [3:0]       wr_addr = '0;
    logic [7:0]       wr_data = '0;
    logic [1:0][19:0] raw_smp = '0;
    logic [1:0][19:0] out_smp;
    logic             pga_mute;
    logic             cal_busy;
    logic [1:0][19:0] offset_val;
    logic [7:0]       pga_gain;

    int     n_chk = 0;
    int     n_fail = 0;
    longint exp_off [2];

    always #4 clk = ~clk;

    adc_cal_seq #(.SETTLE(SETTLE), .AVG_LOG2(AVG_L)) uut (
        .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .smp_stb(smp_stb),
        .pm_en(pm_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .raw_smp(raw_smp), .out_smp(out_smp), .pga_mute(pga_mute),
        .cal_busy(cal_busy), .offset_val(offset_val), .pga_gain(pga_gain)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint pat(input int p, input int ch, input int k);
        if (p == 0) begin
            if (k < SETTLE) return 500000;
            return (ch == 0) ? 1000 + 37 * k : -2001 - 13 * k;
        end else if (p == 1) begin
            if (k < SETTLE) return -524288;
            return (ch == 0) ? 400000 : -300000;
        end else begin
            if (k < SETTLE) return 123456;
            return (ch == 0) ? -400000 + k : 300000 - 3 * k;
        end
    endfunction

    function automatic longint floor_div(input longint s, input longint n);
        if (s >= 0) return s / n;
        return -((-s + n - 1) / n);
    endfunction

    function automatic longint clampv(input longint v);
        if (v > SMAX) return SMAX;
        if (v < SMIN) return SMIN;
        return v;
    endfunction

    task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Release the pin and confirm the three-edge start latency (R2).
    task automatic release_pin();
        pdn_n = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R2 busy before third edge", cal_busy, 0);
        @(negedge clk);
        check("R2 busy on third edge", cal_busy, 1);
    endtask

    // Feed nstb calibration strobes of pattern p; mid_wr adds writes at k==5.
    task automatic feed(input int p, input int nstb, input bit mid_wr);
        longint sum [2];
        sum[0] = 0; sum[1] = 0;
        for (int k = 0; k < nstb; k++) begin
            for (int ch = 0; ch < 2; ch++) begin
                raw_smp[ch] = 20'(pat(p, ch, k));
                if (k >= SETTLE) sum[ch] += pat(p, ch, k);
            end
            smp_stb = 1'b1;
            @(negedge clk);
            smp_stb = 1'b0;
            if (k < CAL_LEN - 1) begin
                check("R4 zero out in cal ch0", longint'($signed(out_smp[0])), 0);
                check("R5 mute in cal", pga_mute, 1);
            end
            if (k == CAL_LEN - 2) check("R3 busy after CAL_LEN-1", cal_busy, 1);
            if (k == CAL_LEN - 1) check("R3 idle after CAL_LEN", cal_busy, 0);
            if (mid_wr && k == 5) begin
                reg_write(4'h1, 8'h00);
                reg_write(4'h2, 8'h3A);
                check("R6 gain write accepted in cal", pga_gain, 8'h3A);
            end
        end
        if (nstb == CAL_LEN) begin
            exp_off[0] = floor_div(sum[0], NAVG);
            exp_off[1] = floor_div(sum[1], NAVG);
        end
    endtask

    task automatic check_offsets(input string tag);
        check({tag, " offset ch0"}, longint'($signed(offset_val[0])), exp_off[0]);
        check({tag, " offset ch1"}, longint'($signed(offset_val[1])), exp_off[1]);
    endtask

    // Sweep inputs across the range and compare with the clamped difference (R8).
    task automatic sweep();
        for (longint v = SMIN; v <= SMAX; v += 4099) begin
            raw_smp[0] = 20'(v);
            raw_smp[1] = 20'(-v - 1);
            @(negedge clk);
            check("R8 corrected ch0", longint'($signed(out_smp[0])), clampv(v - exp_off[0]));
            check("R8 corrected ch1", longint'($signed(out_smp[1])), clampv(-v - 1 - exp_off[1]));
        end
        raw_smp[0] = 20'(SMAX);
        raw_smp[1] = 20'(SMIN);
        @(negedge clk);
        check("R8 top end ch0", longint'($signed(out_smp[0])), clampv(SMAX - exp_off[0]));
        check("R8 bottom end ch1", longint'($signed(out_smp[1])), clampv(SMIN - exp_off[1]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check("R1 reset mute", pga_mute, 1);
        check("R1 reset gain", pga_gain, 8'h0C);
        check("R2 reset busy", cal_busy, 0);
        check("R7 reset offset", longint'($signed(offset_val[0])), 0);

        // Writes and samples while pin is low
        reg_write(4'h2, 8'h55);
        reg_write(4'h1, 8'h00);
        check("R1 gain write ignored in power-down", pga_gain, 8'h0C);
        check("R1 mute write ignored in power-down", pga_mute, 1);
        raw_smp[0] = 20'(77777); raw_smp[1] = 20'(-5);
        @(negedge clk);
        check("R4 zero in pin power-down ch0", longint'($signed(out_smp[0])), 0);
        check("R4 zero in pin power-down ch1", longint'($signed(out_smp[1])), 0);

        // First calibration with a blocked mute write in the middle
        release_pin();
        feed(0, CAL_LEN, 1'b1);
        check_offsets("R7 ramp");
        check("R6 mute write during cal dropped", pga_mute, 1);
        check("R5 still muted after cal", pga_mute, 1);
        reg_write(4'h1, 8'h00);
        check("R5 mute cleared by write", pga_mute, 0);
        sweep();

        // Power management
        pm_en = 2'b10;
        raw_smp[0] = 20'(1234); raw_smp[1] = 20'(1234);
        @(negedge clk);
        check("R9 ch0 off", longint'($signed(out_smp[0])), 0);
        check("R9 ch1 on", longint'($signed(out_smp[1])), clampv(1234 - exp_off[1]));
        pm_en = 2'b01;
        @(negedge clk);
        check("R9 ch1 off", longint'($signed(out_smp[1])), 0);
        pm_en = 2'b11;
        repeat (4) @(negedge clk);
        check("R9 no recal", cal_busy, 0);
        check_offsets("R9 retained");
        check("R9 ch0 back on", longint'($signed(out_smp[0])), clampv(1234 - exp_off[0]));

        // Pin power-down returns registers to defaults
        pdn_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 mute back to default", pga_mute, 1);
        check("R1 gain back to default", pga_gain, 8'h0C);
        check("R4 zero after pin low", longint'($signed(out_smp[0])), 0);

        // Aborted calibration then full rerun with saturating offsets
        release_pin();
        feed(2, 6, 1'b0);
        pdn_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 abort clears busy", cal_busy, 0);
        check_offsets("R10 offset untouched by abort");
        release_pin();
        feed(1, CAL_LEN, 1'b0);
        check_offsets("R7 constant");
        reg_write(4'h1, 8'h00);
        sweep();

        // Negative-leaning pattern exercising floor rounding
        pdn_n = 1'b0;
        repeat (3) @(negedge clk);
        release_pin();
        feed(2, CAL_LEN, 1'b0);
        check_offsets("R7 negative");
        reg_write(4'h1, 8'h00);
        sweep();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule